// File: doc/BRIEF.md
# Host Port Control Register with Command Interrupt Gating

This block holds the 32-bit control word of a host port on a processor with three memory spaces (P, X and Y). The processor writes and reads the word through a simple strobe-and-data register port. One bit of the word is a host-port reset: while it is 1, the host port's status logic and transfer paths are kept in their reset state. That bit comes up as 1 after any hardware or software reset, and it stays at 1 until software writes it to 0.

Six further bits are interrupt enables, one for each memory-space read or write command. The host side reports a pending flag for each such command. A registered interrupt request is raised for a source only when its enable is set, its pending flag is set, and the port is out of host reset. When several requests are active, a fixed priority picks the vector index that is presented to the interrupt controller. The controller maps each index to that source's own starting address.

Top module: `hostctl_top`

## Requirements
- R1: `port_rst` always equals control bit 5. While bit 5 is 1, every pending flag is treated as 0, so `irq_req` is all zero one cycle later.
- R2: After a clock edge with `rst_n` low or `soft_rst` high, bit 5 reads 1. It keeps reading 1 until a write puts 0 in it.
- R3: Bits 0-4, 6, 7 and 14-31 of `rdata` always read 0. Writing 1s to those bits changes nothing that can be observed.
- R4: Bits 8 to 13 are the enables, in this order: P read (bit 8, source 0), P write (bit 9, source 1), X read (bit 10, source 2), X write (bit 11, source 3), Y read (bit 12, source 4), Y write (bit 13, source 5). They read back as written.
- R5: `irq_req[i]` after an edge equals enable i AND `pend[i]` AND NOT bit 5, all sampled on the cycle before that edge.
- R6: When enable i is 0, `irq_req[i]` stays 0 no matter what `pend[i]` does.
- R7: After a clock edge with `rst_n` low or `soft_rst` high, all six enables read 0, and `irq_req`, `irq_any` and `irq_vec` are 0.
- R8: `irq_any` is the OR of `irq_req`. `irq_vec` is the index of the lowest-numbered active request, and it is 0 when no request is active. Both are registered on the same edge as `irq_req`.
- R9: A write (`wr_en` high) updates the register on that clock edge. `rdata` and `port_rst` show the new value right after that edge.
- R10: When `soft_rst` and `wr_en` are both high on the same edge, the reset wins and the write data is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Synchronous active-high software reset of the processor |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Current register contents, reserved bits zero |
| pend | input | 6 | Command-pending flags from the host side, one per source |
| irq_req | output | 6 | Registered per-source interrupt requests |
| irq_any | output | 1 | Registered OR of the requests |
| irq_vec | output | 3 | Registered index of the highest-priority active request |
| port_rst | output | 1 | Host-port reset, equal to control bit 5 |

## Verification
Register effects (`rdata`, `port_rst`) appear right after the edge that carries the write or reset. Interrupt outputs (`irq_req`, `irq_any`, `irq_vec`) appear one edge after the enable, pending or reset-bit values that cause them, so a newly written enable reaches the requests two edges after the write strobe. The bench's reference model advances by exactly one edge per cycle, using the inputs held before that edge. The bench changes inputs and samples outputs 2 ns after each rising edge, so every comparison falls at the cycle in which a result is due. Directed cases cover the reset-then-release sequence, a soft reset that coincides with a write, enables with pending flags held low, and every priority pairing. A long stretch of random writes and pending patterns then follows.

// File: rtl/hostctl_pkg.sv
// Package: shared sizing constants for the host port control block.
// Assumes a single 32-bit control word with the reset bit below the enable field.
package hostctl_pkg;
    localparam int HC_REG_W    = 32;
    localparam int HC_NUM_SRC  = 6;
    localparam int HC_HRES_POS = 5;
    localparam int HC_EN_LSB   = 8;
    localparam int HC_VEC_W    = $clog2(HC_NUM_SRC);

    // Source order, which is also the priority order (lowest index wins).
    typedef enum logic [2:0] {
        SRC_P_RD = 3'd0,
        SRC_P_WR = 3'd1,
        SRC_X_RD = 3'd2,
        SRC_X_WR = 3'd3,
        SRC_Y_RD = 3'd4,
        SRC_Y_WR = 3'd5
    } hc_src_e;
endpackage

// File: rtl/hostctl_ctrl_reg.sv
// Module: the control word itself. It holds the host-reset bit and the enable field.
// Assumes: synchronous active-low rst_n; soft_rst is synchronous and takes
// priority over a write on the same edge. Bits not implemented read 0.
module hostctl_ctrl_reg #(
    parameter int REG_W    = 32,
    parameter int NUM_SRC  = 6,
    parameter int HRES_POS = 5,
    parameter int EN_LSB   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    output logic               hres,
    output logic [NUM_SRC-1:0] en
);
    logic unused_wdata;

    // Only the reset bit and the enable field are taken from the write data.
    assign unused_wdata = ^wdata;

    // Register update: any reset wins, then the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            hres <= 1'b1;
            en   <= '0;
        end else if (wr_en) begin
            hres <= wdata[HRES_POS];
            en   <= wdata[EN_LSB +: NUM_SRC];
        end
    end

    // Read-back assembly: implemented fields in place, zeros elsewhere.
    always_comb begin
        rdata                     = '0;
        rdata[HRES_POS]           = hres;
        rdata[EN_LSB +: NUM_SRC]  = en;
    end
endmodule

// File: rtl/hostctl_irq_gate.sv
// Module: per-source gating of pending flags into registered requests.
// Assumes: the pending flags are already synchronous to clk. The host-reset
// bit masks every flag. The combinational gated vector is exported for the
// priority stage so that both stages register the same value.
module hostctl_irq_gate #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               hres,
    input  logic [NUM_SRC-1:0] en,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] gated,
    output logic [NUM_SRC-1:0] irq_q
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        // Combinational gate for source g.
        always_comb gated[g] = en[g] & pend[g] & ~hres;

        // Request register for source g.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) irq_q[g] <= 1'b0;
            else                    irq_q[g] <= gated[g];
        end
    end
endmodule

// File: rtl/hostctl_prio_enc.sv
// Module: fixed-priority encoder that produces the vector index and the
// any-request flag. The lowest index wins. The index is 0 when nothing is active.
// Assumes: the request vector is the combinational gated vector, so the outputs
// line up in time with the request registers.
module hostctl_prio_enc #(
    parameter int NUM_SRC = 6,
    parameter int VEC_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic [NUM_SRC-1:0] req,
    output logic [VEC_W-1:0]   vec_q,
    output logic               any_q
);
    logic [VEC_W-1:0] vec_d;

    // Priority search from the top down, so the lowest set index is the last one assigned.
    always_comb begin
        vec_d = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) vec_d = VEC_W'(i);
        end
    end

    // Output registers for the index and the any flag.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            vec_q <= '0;
            any_q <= 1'b0;
        end else begin
            vec_q <= vec_d;
            any_q <= |req;
        end
    end
endmodule

// File: rtl/hostctl_top.sv
// Module: host port control register with command interrupt gating.
// Assumes: one register, always selected by wr_en. rdata is read combinationally.
// Interrupt outputs lag their causes by one edge.
module hostctl_top
    import hostctl_pkg::*;
#(
    parameter int REG_W    = HC_REG_W,
    parameter int NUM_SRC  = HC_NUM_SRC,
    parameter int HRES_POS = HC_HRES_POS,
    parameter int EN_LSB   = HC_EN_LSB,
    parameter int VEC_W    = HC_VEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wdata,
    output logic [REG_W-1:0]   rdata,
    input  logic [NUM_SRC-1:0] pend,
    output logic [NUM_SRC-1:0] irq_req,
    output logic               irq_any,
    output logic [VEC_W-1:0]   irq_vec,
    output logic               port_rst
);
    logic               hres;
    logic [NUM_SRC-1:0] en;
    logic [NUM_SRC-1:0] gated;

    hostctl_ctrl_reg #(
        .REG_W(REG_W), .NUM_SRC(NUM_SRC), .HRES_POS(HRES_POS), .EN_LSB(EN_LSB)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .hres(hres), .en(en)
    );

    hostctl_irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .hres(hres),
        .en(en), .pend(pend), .gated(gated), .irq_q(irq_req)
    );

    hostctl_prio_enc #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .req(gated),
        .vec_q(irq_vec), .any_q(irq_any)
    );

    // Host-port reset output follows the control bit directly.
    assign port_rst = hres;
endmodule

// File: rtl/hostctl_chk.sv
// Module: assertion checker bound to hostctl_top. It watches ports only.
module hostctl_chk #(
    parameter int REG_W    = 32,
    parameter int NUM_SRC  = 6,
    parameter int HRES_POS = 5,
    parameter int EN_LSB   = 8,
    parameter int VEC_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               soft_rst,
    input logic               wr_en,
    input logic [REG_W-1:0]   wdata,
    input logic [REG_W-1:0]   rdata,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] irq_req,
    input logic               irq_any,
    input logic [VEC_W-1:0]   irq_vec,
    input logic               port_rst
);
    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << HRES_POS) | (((REG_W'(1) << NUM_SRC) - REG_W'(1)) << EN_LSB);

    function automatic logic [NUM_SRC-1:0] below(input logic [VEC_W-1:0] v);
        return (NUM_SRC'(1) << v) - NUM_SRC'(1);
    endfunction

    // R1
    port_rst_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst == rdata[HRES_POS]);

    // R1
    hres_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst |=> irq_req == '0);

    // R2
    hres_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rst && !wr_en && !soft_rst) |=> port_rst);

    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~IMPL_MASK) == '0);

    // R5
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(soft_rst) |-> irq_req ==
            ($past(rdata[EN_LSB +: NUM_SRC] & pend) & {NUM_SRC{!$past(port_rst)}}));

    // R7
    soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (port_rst && rdata[EN_LSB +: NUM_SRC] == '0 && irq_req == '0));

    // R8
    any_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == (|irq_req));

    // R8
    vec_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |-> (irq_req[irq_vec] && (irq_req & below(irq_vec)) == '0));

    // R8
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_any |-> irq_vec == '0);

    // R9
    write_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> (port_rst == $past(wdata[HRES_POS]) &&
            rdata[EN_LSB +: NUM_SRC] == $past(wdata[EN_LSB +: NUM_SRC])));
endmodule

bind hostctl_top hostctl_chk #(
    .REG_W(REG_W), .NUM_SRC(NUM_SRC), .HRES_POS(HRES_POS),
    .EN_LSB(EN_LSB), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .pend(pend), .irq_req(irq_req),
    .irq_any(irq_any), .irq_vec(irq_vec), .port_rst(port_rst)
);

// File: tb/test_hostctl_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model that advances one edge per cycle and is compared on every cycle.
module test_hostctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  pend = '0;
    logic [5:0]  irq_req;
    logic        irq_any;
    logic [2:0]  irq_vec;
    logic        port_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Model state
    int m_hres = 1;
    int m_en   = 0;
    int m_irq  = 0;
    int m_vec  = 0;
    int m_any  = 0;

    always #4 clk = ~clk;

    hostctl_top i_hostctl_top (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .pend(pend), .irq_req(irq_req),
        .irq_any(irq_any), .irq_vec(irq_vec), .port_rst(port_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance model and design by one edge, then compare all outputs.
    task automatic tick();
        int n_hres, n_en, n_irq, n_vec, n_any;
        n_hres = m_hres; n_en = m_en;
        if (!rst_n || soft_rst) begin
            n_hres = 1; n_en = 0; n_irq = 0; n_vec = 0; n_any = 0;
        end else begin
            n_irq = (m_hres != 0) ? 0 : (m_en & int'(pend));
            n_any = (n_irq != 0) ? 1 : 0;
            n_vec = 0;
            for (int k = 0; k < 6; k++) begin
                if ((n_irq >> k) & 1) begin n_vec = k; break; end
            end
            if (wr_en) begin
                n_hres = (wdata >> 5) & 1;
                n_en   = (wdata >> 8) & 'h3f;
            end
        end
        @(posedge clk);
        #2;
        m_hres = n_hres; m_en = n_en; m_irq = n_irq; m_vec = n_vec; m_any = n_any;
        chk("R3 reserved bits", int'(rdata & ~32'h3f20), 0);
        chk("R2/R9 host reset bit", int'(rdata[5]), m_hres);
        chk("R1 port_rst", int'(port_rst), m_hres);
        chk("R4/R7 enable field", int'(rdata[13:8]), m_en);
        chk("R5/R6 irq_req", int'(irq_req), m_irq);
        chk("R8 irq_any", int'(irq_any), m_any);
        chk("R8 irq_vec", int'(irq_vec), m_vec);
    endtask

    task automatic drive(input bit we, input logic [31:0] wd, input logic [5:0] pd, input bit sr);
        wr_en = we; wdata = wd; pend = pd; soft_rst = sr;
        tick();
    endtask

    initial begin
        // R7 reset state
        rst_n = 1'b0;
        pend = 6'h3f;
        repeat (3) tick();
        rst_n = 1'b1;
        // R2 bit stays 1 with pending high and no write; R1 no requests
        drive(0, '0, 6'h3f, 0);
        drive(0, '0, 6'h3f, 0);
        // R3 write all ones: reserved ignored, hres stays 1, R1 suppresses
        drive(1, 32'hffff_ffff, 6'h3f, 0);
        drive(0, '0, 6'h3f, 0);
        drive(0, '0, 6'h3f, 0);
        // Release host reset, all enables on (R4)
        drive(1, 32'h0000_3f00, 6'h3f, 0);
        drive(0, '0, 6'h3f, 0);
        // R8 priority sweep, each single source then pairs
        for (int s = 0; s < 6; s++) drive(0, '0, 6'(1 << s), 0);
        for (int a = 0; a < 6; a++)
            for (int b = a + 1; b < 6; b++) drive(0, '0, 6'((1 << a) | (1 << b)), 0);
        drive(0, '0, 6'h00, 0);
        // R6 enable 0 with pending toggling
        drive(1, 32'h0000_2a00, 6'h3f, 0);
        drive(0, '0, 6'h15, 0);
        drive(0, '0, 6'h3f, 0);
        // R10 soft reset with a simultaneous write
        drive(1, 32'h0000_3f00, 6'h3f, 1);
        drive(0, '0, 6'h3f, 0);
        drive(1, 32'h0000_3f00, 6'h3f, 0);
        drive(0, '0, 6'h3f, 0);
        // R7 soft reset clears outputs
        drive(0, '0, 6'h3f, 1);
        drive(0, '0, 6'h3f, 0);
        // Random stretch
        for (int r = 0; r < 400; r++) begin
            logic [31:0] w;
            w = $urandom;
            if (($urandom % 4) != 0) w[5] = 1'b0;
            drive(($urandom % 5) == 0, w, 6'($urandom), ($urandom % 40) == 0);
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule